// File: doc/BRIEF.md
# Self-Synchronizing Parallel Scrambler and Descrambler Pair

This block carries two independent directions of a multiplicative, self-synchronizing scrambler built on the polynomial 1 + x^39 + x^58. Each direction takes one 64-bit word per valid clock. The transmit lane scrambles the word, and the receive lane descrambles it. Serial order within a word runs from bit 0, the earliest bit, to bit 63, the latest. Both lanes keep a 58-bit history of line bits.

The transmit lane feeds back its own scrambled output. The receive lane shifts in the line bits it receives. The receive history is therefore filled from the line alone. After one full word has been received, the receive lane reproduces the original data whatever state it started from. No seed agreement or alignment is needed.

All bit dependencies inside one word are resolved combinationally. Every direction has one register stage: the output word and its valid flag appear on the clock edge after the input. A history that is all zero, fed with all-zero data, legitimately produces all-zero line data.

Top module: `ssc_pair`

## Requirements
- R1: On a valid transmit cycle, scrambled bit k equals input bit k XOR the scrambled bits 39 and 58 positions earlier in serial order. Bit 0 is the earliest bit, and earlier words supply the bits that precede bit 0. The result appears on `tx_out` one clock later.
- R2: On a valid receive cycle, descrambled bit k equals received bit k XOR the received bits 39 and 58 positions earlier in serial order. The result appears on `rx_out` one clock later.
- R3: After a valid cycle, each history holds the last 58 line bits in serial order: scrambled bits for transmit and received bits for receive. The following word is computed from exactly these bits.
- R4: A cycle with its valid low leaves that lane's history unchanged. Idle cycles inserted anywhere in the stream do not alter any later output.
- R5: `tx_out_valid` and `rx_out_valid` equal the corresponding input valid of the previous clock. On a cycle after an idle input, the data output keeps its previous value.
- R6: While reset (`rst_n` low) is asserted, both output valids and both data outputs are zero. The transmit history starts from `TX_SEED` and the receive history from `RX_SEED`. Bit HIST_LEN-1 of a seed is the most recent bit.
- R7: In either lane, an all-zero history with an all-zero input word gives an all-zero output word.
- R8: Once one full 64-bit word of scrambled data has been received, every later valid receive word equals the original transmit data. This holds even when `RX_SEED` differs from `TX_SEED`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit word present |
| tx_data | input | 64 | Plain transmit word, bit 0 earliest |
| tx_out_valid | output | 1 | Scrambled word present |
| tx_out | output | 64 | Scrambled transmit word |
| rx_valid | input | 1 | Received word present |
| rx_data | input | 64 | Scrambled received word, bit 0 earliest |
| rx_out_valid | output | 1 | Descrambled word present |
| rx_out | output | 64 | Descrambled word |

## Verification
A corrupted transmit history shows up in the first scrambled word after the fault, in the bit positions whose 39- or 58-bit taps reach into the history. A transmit history that advances on an idle cycle shows up the same way on the next valid word. The receive lane flushes any wrong history within one word. A receive fault is therefore visible only in the single word that follows it. The bench compares every valid word against a bit-serial model, starting from deliberately mismatched seeds, so these one-word windows are not missed.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic {
      SSC_SCRAMBLE   = 1'b0,
      SSC_DESCRAMBLE = 1'b1
   } ssc_dir_e;

   localparam int unsigned SSC_WORD_W_DEF = 64;
   localparam int unsigned SSC_FAR_DEF    = 58;
   localparam int unsigned SSC_NEAR_DEF   = 39;
endpackage

// File: rtl/ssc_hist.sv
module ssc_hist #(
   parameter int unsigned      LEN  = 58,
   parameter logic [LEN-1:0]   SEED = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv,
   input  logic [LEN-1:0] nxt,
   output logic [LEN-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= SEED;
      else if (adv) q <= nxt;
   end

   // R4: an idle cycle leaves the history untouched
   p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(q));
endmodule

// File: rtl/ssc_lane.sv
module ssc_lane
   import ssc_pkg::*;
#(
   parameter int unsigned   W    = 64,
   parameter int unsigned   L    = 58,
   parameter int unsigned   NEAR = 39,
   parameter ssc_dir_e      DIR  = SSC_SCRAMBLE,
   parameter logic [L-1:0]  SEED = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   localparam int unsigned EXT_W = L + W;

   generate
      if (NEAR == 0 || NEAR >= L) begin : g_bad_tap
         $error("ssc_lane: NEAR tap must lie strictly inside the history");
      end
      if (W == 0) begin : g_bad_width
         $error("ssc_lane: word width must be nonzero");
      end
   endgenerate

   logic [L-1:0]     hist_q;
   logic [EXT_W-1:0] ext;
   logic [W-1:0]     word_nxt;

   // Multiplicative scrambling: line bits feed back, resolved serially in one cycle.
   function automatic logic [EXT_W-1:0] scr_chain(input logic [L-1:0] h,
                                                  input logic [W-1:0] d);
      logic [EXT_W-1:0] e;
      e = '0;
      e[L-1:0] = h;
      for (int k = 0; k < W; k++) begin
         e[L+k] = d[k] ^ e[L+k-NEAR] ^ e[k];
      end
      return e;
   endfunction

   // Descrambling: taps read received bits only, so no chain inside the word.
   function automatic logic [W-1:0] dsc_word(input logic [EXT_W-1:0] e);
      logic [W-1:0] r;
      for (int k = 0; k < W; k++) begin
         r[k] = e[L+k] ^ e[L+k-NEAR] ^ e[k];
      end
      return r;
   endfunction

   generate
      if (DIR == SSC_SCRAMBLE) begin : g_scr
         always_comb begin
            ext      = scr_chain(hist_q, in_data);
            word_nxt = ext[EXT_W-1:L];
         end
      end else begin : g_dsc
         always_comb begin
            ext      = {in_data, hist_q};
            word_nxt = dsc_word(ext);
         end
      end
   endgenerate

   ssc_hist #(.LEN(L), .SEED(SEED)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (in_valid),
      .nxt   (ext[EXT_W-1:W]),
      .q     (hist_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= word_nxt;
      end
   end

   // R5: output valid follows input valid by one clock
   p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R5: output word held after an idle input
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));
   // R7: zero history with zero data yields a zero word
   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hist_q == '0 && in_data == '0) |=> out_data == '0);

   generate
      if (W >= L) begin : g_hist_chk
         if (DIR == SSC_SCRAMBLE) begin : g_scr_chk
            // R3: transmit history is the tail of the emitted scrambled word
            p_hist_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
               in_valid |=> hist_q == out_data[W-1:W-L]);
         end else begin : g_dsc_chk
            // R3: receive history is the tail of the received word
            p_hist_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
               in_valid |=> hist_q == $past(in_data[W-1:W-L]));
         end
      end
   endgenerate
endmodule

// File: rtl/ssc_pair.sv
module ssc_pair
   import ssc_pkg::*;
#(
   parameter int unsigned             DATA_W   = SSC_WORD_W_DEF,
   parameter int unsigned             HIST_LEN = SSC_FAR_DEF,
   parameter int unsigned             NEAR_TAP = SSC_NEAR_DEF,
   parameter logic [HIST_LEN-1:0]     TX_SEED  = '1,
   parameter logic [HIST_LEN-1:0]     RX_SEED  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_out_valid,
   output logic [DATA_W-1:0] tx_out,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_out_valid,
   output logic [DATA_W-1:0] rx_out
);
   ssc_lane #(
      .W(DATA_W), .L(HIST_LEN), .NEAR(NEAR_TAP),
      .DIR(SSC_SCRAMBLE), .SEED(TX_SEED)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (tx_valid),
      .in_data   (tx_data),
      .out_valid (tx_out_valid),
      .out_data  (tx_out)
   );

   ssc_lane #(
      .W(DATA_W), .L(HIST_LEN), .NEAR(NEAR_TAP),
      .DIR(SSC_DESCRAMBLE), .SEED(RX_SEED)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_valid),
      .in_data   (rx_data),
      .out_valid (rx_out_valid),
      .out_data  (rx_out)
   );

   // R6: nothing is presented while reset is held
   p_reset_quiet_r6: assert property (@(posedge clk)
      !rst_n |=> (!tx_out_valid && !rx_out_valid && tx_out == '0 && rx_out == '0));
endmodule

// File: tb/sim_ssc_pair.sv
module sim_ssc_pair;
   localparam int W = 64;
   localparam int L = 58;
   localparam int N = 39;
   localparam logic [L-1:0] TS = 58'h155_5555_AAAA_3C3C;
   localparam logic [L-1:0] RS = 58'h0F0_0FF0_1234_8765;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_valid = 1'b0, rx_valid = 1'b0;
   logic [W-1:0] tx_data = '0, rx_data = '0;
   logic tx_out_valid, rx_out_valid;
   logic [W-1:0] tx_out, rx_out;

   int total = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ssc_pair #(.DATA_W(W), .HIST_LEN(L), .NEAR_TAP(N), .TX_SEED(TS), .RX_SEED(RS)) u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_out_valid(tx_out_valid), .tx_out(tx_out),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_out_valid(rx_out_valid), .rx_out(rx_out)
   );

   // bit-serial model state: index 0 is the newest line bit
   logic [L-1:0] mt, mr;
   logic [W-1:0] exp_tx, exp_rx;

   function automatic logic [L-1:0] to_serial(input logic [L-1:0] s);
      logic [L-1:0] r;
      for (int i = 0; i < L; i++) r[i] = s[L-1-i];
      return r;
   endfunction

   task automatic m_scr(input logic [W-1:0] d, output logic [W-1:0] o);
      for (int k = 0; k < W; k++) begin
         o[k] = d[k] ^ mt[N-1] ^ mt[L-1];
         mt = {mt[L-2:0], o[k]};
      end
   endtask

   task automatic m_dsc(input logic [W-1:0] d, output logic [W-1:0] o);
      for (int k = 0; k < W; k++) begin
         o[k] = d[k] ^ mr[N-1] ^ mr[L-1];
         mr = {mr[L-2:0], d[k]};
      end
   endtask

   // input word that drives the scrambled output to zero (flushes the history)
   task automatic m_zeroing(output logic [W-1:0] d);
      logic [L-1:0] h;
      h = mt;
      for (int k = 0; k < W; k++) begin
         d[k] = h[N-1] ^ h[L-1];
         h = {h[L-2:0], 1'b0};
      end
   endtask

   task automatic chk1(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // called at a negedge: drive, then check at the following negedge
   task automatic cyc(input logic tv, input logic [W-1:0] td,
                      input logic rv, input logic [W-1:0] rd, input string tag);
      logic [W-1:0] o;
      tx_valid = tv; tx_data = td; rx_valid = rv; rx_data = rd;
      if (tv) begin m_scr(td, o); exp_tx = o; end
      if (rv) begin m_dsc(rd, o); exp_rx = o; end
      @(negedge clk);
      chk1({tag, " R5 tx valid"}, tx_out_valid, tv);
      chk1({tag, " R5 rx valid"}, rx_out_valid, rv);
      chk({tag, " R1/R5 tx word"}, tx_out, exp_tx);
      chk({tag, " R2/R5 rx word"}, rx_out, exp_rx);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] d, s, zw;
      logic tv;
      int first;
      void'($urandom(32'd7));
      mt = to_serial(TS); mr = to_serial(RS);
      exp_tx = '0; exp_rx = '0;
      repeat (3) @(negedge clk);
      // R6: reset state
      chk1("R6 tx_out_valid in reset", tx_out_valid, 1'b0);
      chk1("R6 rx_out_valid in reset", rx_out_valid, 1'b0);
      chk("R6 tx_out in reset", tx_out, '0);
      chk("R6 rx_out in reset", rx_out, '0);
      rst_n = 1'b1;

      // R7: flush tx history to zero, then zero in gives zero out; same for rx
      m_zeroing(zw);
      cyc(1'b1, zw, 1'b1, '0, "R7 flush");
      chk("R7 flushing word scrambles to zero", tx_out, '0);
      cyc(1'b1, '0, 1'b1, '0, "R7 zero");
      chk("R7 tx zero history zero data", tx_out, '0);
      chk("R7 rx zero history zero data", rx_out, '0);

      // R1/R3: directed patterns into a zero history
      cyc(1'b1, 64'h1, 1'b0, '0, "R1 single bit");
      cyc(1'b1, '1, 1'b0, '0, "R1 all ones");
      cyc(1'b1, 64'h8000_0000_0000_0000, 1'b0, '0, "R3 top bit");

      // R4: idle run, then the stream resumes unaffected
      cyc(1'b0, '1, 1'b0, '1, "R4 idle a");
      cyc(1'b0, 64'hDEAD_BEEF_0000_1111, 1'b0, 64'h1234, "R4 idle b");
      cyc(1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 1'b1, 64'h0123_4567_89AB_CDEF, "R4 resume");

      // R8: fresh reset with mismatched seeds, loop transmit model output into receive
      rst_n = 1'b0; tx_valid = 0; rx_valid = 0;
      @(negedge clk);
      rst_n = 1'b1;
      mt = to_serial(TS); mr = to_serial(RS); exp_tx = '0; exp_rx = '0;
      first = 1;
      for (int i = 0; i < 300; i++) begin
         tv = ($urandom % 4) != 0;
         d = {$urandom, $urandom};
         if (i % 50 == 7) d = '0;
         if (i % 50 == 21) d = '1;
         if (tv) begin
            logic [L-1:0] save;
            save = mt;
            m_scr(d, s);
            mt = save;
         end else s = {$urandom, $urandom};
         cyc(tv, d, tv, s, "R8 loop");
         if (tv) begin
            if (!first) chk("R8 descrambled equals original", rx_out, d);
            first = 0;
         end
      end

      // R1/R2/R4: independent random streams on both lanes
      for (int i = 0; i < 400; i++) begin
         cyc(($urandom % 3) != 0, {$urandom, $urandom},
             ($urandom % 3) != 0, {$urandom, $urandom}, "R1 R2 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule